// File: doc/BRIEF.md
# Synchronous-to-Asynchronous Character Regenerator

This block sits on the receive side of a link that carries start-stop characters inside a synchronous network stream. It watches the recovered bit stream, one bit per valid strobe. It picks out whole characters, each made of a start bit, a payload and a stop bit. It places each payload in a small buffer and sends it out again as an asynchronous character on a serial line toward user equipment. Output bit timing comes from a 16x baud enable that the surrounding logic derives from a clock locked to the network receiver.

The far end may send slightly faster than the local baud rate. Characters are never dropped for that reason. When the buffer holds more than a high-water level at the moment a stop bit begins, that stop bit is cut from 16 to 12 enable ticks. The output then catches up. The payload carries the parity bit along with the data bits, so parity reaches the user unchanged. While frame synchronisation is lost, the output rests at mark and everything held is discarded.

Top module: `s2a_conv`

## Requirements
- R1: After reset, and whenever no character is being sent, `txd` is 1 (mark). `buf_hi`, `stop_short` and `ovr` are 0 after reset.
- R2: `len_sel` sets the total character length: 0 gives 9 bits, 1 gives 10 bits, 2 gives 11 bits (3 behaves as 10). The payload is the total minus 2 bits. On `txd` the character is a 0 start bit, then the payload least significant bit first, then a 1 stop bit. The start bit and each payload bit last 16 `baud_en` ticks.
- R3: The input side only considers `sd_bit` in cycles where `sd_valid` is 1. A 0 bit starts a character only if the previous considered bit was 1. After sync is gained, a mark bit must be seen before the first start.
- R4: Every accepted payload, parity bit included, appears on `txd` unchanged and in arrival order.
- R5: `buf_hi` is 1 while the buffer holds more than `HI_WATER` characters. A stop bit lasts `SHORT_TICKS` (12) ticks if the buffer held more than `HI_WATER` characters when that stop bit began, and 16 ticks otherwise. `stop_short` is 1 during a shortened stop bit.
- R6: While `sync_ok` is 0, `txd` is 1 from the next cycle on, the buffer is emptied, and input bits are ignored. No character from before or during the loss appears later.
- R7: A received character whose stop bit is 0 is discarded.
- R8: A character that arrives while the buffer holds `DEPTH` characters is dropped, and `ovr` is 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, locked to the network receiver |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_ok | input | 1 | Frame synchronisation achieved |
| sd_bit | input | 1 | Recovered synchronous data bit |
| sd_valid | input | 1 | Strobe marking `sd_bit` as a new bit |
| baud_en | input | 1 | 16x output baud enable |
| len_sel | input | 2 | Character length select |
| txd | output | 1 | Asynchronous serial output |
| buf_hi | output | 1 | Buffer above high-water level |
| stop_short | output | 1 | A shortened stop bit is being sent |
| ovr | output | 1 | One-cycle pulse on a dropped character |

## Verification
The bench decodes `txd` itself and measures the time from one start edge to the next. A design that shortened stop bits at the wrong moment, or by the wrong amount, would give intervals outside the two allowed widths. A slow stream must never shorten at all, while a burst followed by a slightly fast steady stream must shorten. The directed cases cover the following:
- payloads of all ones and all zeros at every length;
- a 0 seen first after sync with no mark before it, which must not start a character;
- a character with a 0 stop bit, which must be dropped;
- line noise while `sd_valid` is low, which must be ignored;
- a sync loss with a full buffer, after which any buffered character that leaked out would show up as an unexpected character.

// File: rtl/s2a_pkg.sv
package s2a_pkg;
   localparam int unsigned PAY_MAX = 9;

   typedef enum logic [1:0] {
      CHR_9  = 2'd0,
      CHR_10 = 2'd1,
      CHR_11 = 2'd2,
      CHR_RS = 2'd3
   } chr_len_e;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_STOP
   } tx_state_e;

   function automatic logic [3:0] pay_bits(input logic [1:0] sel);
      case (sel)
         CHR_9:   pay_bits = 4'd7;
         CHR_11:  pay_bits = 4'd9;
         default: pay_bits = 4'd8;
      endcase
   endfunction
endpackage

// File: rtl/s2a_deframe.sv
module s2a_deframe
   import s2a_pkg::*;
#(
   parameter int unsigned PW = PAY_MAX
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_ok,
   input  logic          bit_i,
   input  logic          bit_vld,
   input  logic [1:0]    len_sel,
   output logic          chr_vld,
   output logic [PW-1:0] chr_data
);
   logic          armed;
   logic          busy;
   logic [3:0]    idx;
   logic [PW-1:0] shreg;
   logic [3:0]    nb;

   assign nb = pay_bits(len_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         busy     <= 1'b0;
         idx      <= '0;
         shreg    <= '0;
         chr_vld  <= 1'b0;
         chr_data <= '0;
      end else begin
         chr_vld <= 1'b0;
         if (!sync_ok) begin
            armed <= 1'b0;
            busy  <= 1'b0;
         end else if (bit_vld) begin
            if (!busy) begin
               if (bit_i) begin
                  armed <= 1'b1;
               end else if (armed) begin
                  busy  <= 1'b1;
                  idx   <= '0;
                  shreg <= '0;
               end
            end else if (idx == nb) begin
               busy  <= 1'b0;
               armed <= bit_i;
               if (bit_i) begin
                  chr_vld  <= 1'b1;
                  chr_data <= shreg;
               end
            end else begin
               shreg[idx] <= bit_i;
               idx        <= idx + 4'd1;
            end
         end
      end
   end

   // R7
   stop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_vld |-> ($past(bit_vld) && $past(bit_i) && $past(sync_ok)));
endmodule

// File: rtl/s2a_fifo.sv
module s2a_fifo #(
   parameter int unsigned W     = 9,
   parameter int unsigned DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         drop
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit          POW2 = (DEPTH == (1 << AW));

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic          do_wr, do_rd;

   assign full  = (count == CW'(DEPTH));
   assign do_wr = push && !full && !flush;
   assign do_rd = pop && (count != '0) && !flush;
   assign drop  = push && full && !flush;
   assign dout  = mem[rp];

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp + AW'(1);
         assign rp_nx = rp + AW'(1);
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_wr) wp <= wp_nx;
         if (do_rd) rp <= rp_nx;
         count <= count + CW'(do_wr) - CW'(do_rd);
      end
   end

   // R8
   overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
   // R6
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
endmodule

// File: rtl/s2a_serial.sv
module s2a_serial
   import s2a_pkg::*;
#(
   parameter int unsigned PW          = PAY_MAX,
   parameter int unsigned CW          = 4,
   parameter int unsigned TICKS       = 16,
   parameter int unsigned SHORT_TICKS = 12,
   parameter int unsigned HI_WATER    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_ok,
   input  logic          baud_en,
   input  logic [1:0]    len_sel,
   input  logic          buf_empty,
   input  logic [PW-1:0] buf_data,
   input  logic [CW-1:0] fill,
   output logic          pop,
   output logic          txd,
   output logic          stop_short
);
   localparam int unsigned TW = $clog2(TICKS);

   tx_state_e     st;
   logic [TW-1:0] tick;
   logic [3:0]    idx;
   logic [3:0]    nb_q;
   logic [PW-1:0] shreg;
   logic          short_q;
   logic          bit_end;
   logic [TW-1:0] stop_last;

   assign pop        = (st == TX_IDLE) && sync_ok && !buf_empty;
   assign stop_last  = short_q ? TW'(SHORT_TICKS - 1) : TW'(TICKS - 1);
   assign bit_end    = baud_en && (tick == ((st == TX_STOP) ? stop_last : TW'(TICKS - 1)));
   assign stop_short = (st == TX_STOP) && short_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !sync_ok) begin
         st      <= TX_IDLE;
         txd     <= 1'b1;
         tick    <= '0;
         idx     <= '0;
         nb_q    <= '0;
         shreg   <= '0;
         short_q <= 1'b0;
      end else begin
         if (baud_en && st != TX_IDLE) tick <= bit_end ? '0 : tick + TW'(1);
         case (st)
            TX_IDLE: begin
               txd <= 1'b1;
               if (pop) begin
                  shreg <= buf_data;
                  nb_q  <= pay_bits(len_sel);
                  tick  <= '0;
                  txd   <= 1'b0;
                  st    <= TX_START;
               end
            end
            TX_START: if (bit_end) begin
               idx <= '0;
               txd <= shreg[0];
               st  <= TX_DATA;
            end
            TX_DATA: if (bit_end) begin
               if (idx == nb_q - 4'd1) begin
                  txd     <= 1'b1;
                  short_q <= (fill > CW'(HI_WATER));
                  st      <= TX_STOP;
               end else begin
                  idx   <= idx + 4'd1;
                  txd   <= shreg[1];
                  shreg <= shreg >> 1;
               end
            end
            default: if (bit_end) begin
               short_q <= 1'b0;
               st      <= TX_IDLE;
            end
         endcase
      end
   end

   // R6
   sync_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_ok |=> txd);
   // R1
   idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_IDLE && !$past(pop)) |-> txd);
   // R4
   pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !buf_empty);
endmodule

// File: rtl/s2a_conv.sv
module s2a_conv
   import s2a_pkg::*;
#(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned HI_WATER    = 4,
   parameter int unsigned TICKS       = 16,
   parameter int unsigned SHORT_TICKS = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_ok,
   input  logic       sd_bit,
   input  logic       sd_valid,
   input  logic       baud_en,
   input  logic [1:0] len_sel,
   output logic       txd,
   output logic       buf_hi,
   output logic       stop_short,
   output logic       ovr
);
   localparam int unsigned PW = PAY_MAX;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (HI_WATER >= DEPTH) begin : g_bad_hw
         $error("HI_WATER must be below DEPTH");
      end
      if (SHORT_TICKS == 0 || SHORT_TICKS >= TICKS) begin : g_bad_short
         $error("SHORT_TICKS must lie in 1..TICKS-1");
      end
      if (TICKS != (1 << $clog2(TICKS))) begin : g_bad_ticks
         $error("TICKS must be a power of two");
      end
   endgenerate

   logic          chr_vld;
   logic [PW-1:0] chr_data;
   logic [PW-1:0] buf_data;
   logic [CW-1:0] fill;
   logic          buf_full;
   logic          drop;
   logic          pop;

   s2a_deframe #(.PW(PW)) u_deframe (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_ok  (sync_ok),
      .bit_i    (sd_bit),
      .bit_vld  (sd_valid),
      .len_sel  (len_sel),
      .chr_vld  (chr_vld),
      .chr_data (chr_data)
   );

   s2a_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!sync_ok),
      .push  (chr_vld),
      .din   (chr_data),
      .pop   (pop),
      .dout  (buf_data),
      .count (fill),
      .full  (buf_full),
      .drop  (drop)
   );

   s2a_serial #(
      .PW(PW), .CW(CW), .TICKS(TICKS),
      .SHORT_TICKS(SHORT_TICKS), .HI_WATER(HI_WATER)
   ) u_serial (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_ok    (sync_ok),
      .baud_en    (baud_en),
      .len_sel    (len_sel),
      .buf_empty  (fill == '0),
      .buf_data   (buf_data),
      .fill       (fill),
      .pop        (pop),
      .txd        (txd),
      .stop_short (stop_short)
   );

   assign buf_hi = (fill > CW'(HI_WATER));

   always_ff @(posedge clk) begin
      if (!rst_n) ovr <= 1'b0;
      else        ovr <= drop;
   end

   // R8
   ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> $past(buf_full));
endmodule

// File: tb/s2a_conv_tb.sv
module s2a_conv_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CYC    = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_ok = 1'b0;
   logic       sd_bit = 1'b1;
   logic       sd_valid = 1'b0;
   logic       baud_en = 1'b0;
   logic [1:0] len_sel = 2'd1;
   logic       txd, buf_hi, stop_short, ovr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int dec_cnt = 0;
   int short_cnt = 0;
   int bad_stop = 0;
   bit cmp_en = 1'b1;
   bit seen_ovr = 1'b0;
   bit seen_hi = 1'b0;
   bit seen_short = 1'b0;
   bit seen_low = 1'b0;
   logic [8:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   s2a_conv u_dut (
      .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .sd_bit(sd_bit),
      .sd_valid(sd_valid), .baud_en(baud_en), .len_sel(len_sel),
      .txd(txd), .buf_hi(buf_hi), .stop_short(stop_short), .ovr(ovr)
   );

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) baud_en <= ~baud_en;

   always @(negedge clk) begin
      if (ovr) seen_ovr = 1'b1;
      if (buf_hi) seen_hi = 1'b1;
      if (stop_short) seen_short = 1'b1;
      if (!txd) seen_low = 1'b1;
   end

   function automatic int nbits(input logic [1:0] s);
      return (s == 2'd0) ? 7 : (s == 2'd2) ? 9 : 8;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Receiver model on txd
   initial begin : decoder
      int   t_prev;
      bit   have_prev;
      have_prev = 1'b0;
      t_prev = 0;
      forever begin
         @(negedge clk);
         if (rst_n && txd == 1'b0) begin
            int t0, nb, ivl, nom;
            logic [8:0] pay;
            t0 = cyc;
            nb = nbits(len_sel);
            pay = '0;
            if (have_prev) begin
               ivl = t0 - t_prev;
               nom = (nb + 2) * BIT_CYC;
               if (ivl < nom - 4) short_cnt++;
               if (ivl < (nb + 1) * BIT_CYC + 24 - 2) bad_stop++;
            end
            t_prev = t0;
            have_prev = 1'b1;
            repeat (BIT_CYC/2) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
               repeat (BIT_CYC) @(negedge clk);
               pay[i] = txd;
            end
            repeat (BIT_CYC) @(negedge clk);
            dec_cnt++;
            // R2: stop bit is mark
            check(txd == 1'b1, "R2 stop bit", txd, 1);
            if (cmp_en) begin
               if (exp_q.size() == 0) begin
                  // R4: no character beyond those expected
                  check(1'b0, "R4 unexpected char", pay, -1);
               end else begin
                  logic [8:0] e;
                  e = exp_q.pop_front();
                  // R4: payload and parity unchanged
                  check(pay == e, "R4 payload", pay, e);
               end
            end
         end else if (!sync_ok) begin
            have_prev = 1'b0;
         end
      end
   end

   task automatic put_bit(input logic b, input int p);
      @(negedge clk);
      sd_bit   = b;
      sd_valid = 1'b1;
      @(negedge clk);
      sd_valid = 1'b0;
      sd_bit   = $urandom_range(0, 1);
      repeat (p - 2) @(negedge clk);
   endtask

   task automatic send_char(input logic [8:0] pay, input logic stopb, input int p, input bit expect_it);
      int nb;
      nb = nbits(len_sel);
      put_bit(1'b0, p);
      for (int i = 0; i < nb; i++) put_bit(pay[i], p);
      put_bit(stopb, p);
      if (expect_it) exp_q.push_back(pay & ((9'd1 << nb) - 9'd1));
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (600) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : stim
      int s0, d0, p;
      void'($urandom(32'h5A17));
      repeat (4) @(negedge clk);
      // R1: reset state
      check(txd == 1'b1, "R1 txd at reset", txd, 1);
      check({buf_hi, stop_short, ovr} == 3'b000, "R1 flags at reset", {buf_hi, stop_short, ovr}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      sync_ok = 1'b1;
      put_bit(1'b1, 4);

      // R2/R4: each length, directed extremes plus random payloads
      for (int l = 0; l < 3; l++) begin
         len_sel = 2'(l);
         put_bit(1'b1, 40);
         d0 = dec_cnt;
         send_char(9'h1FF, 1'b1, 40, 1'b1);
         send_char(9'h000, 1'b1, 40, 1'b1);
         for (int k = 0; k < 5; k++) send_char(9'($urandom), 1'b1, 40, 1'b1);
         drain();
         // R2: every character for this length decoded
         check(dec_cnt - d0 == 7, "R2 char count per length", dec_cnt - d0, 7);
      end
      len_sel = 2'd1;

      // R1/R3: noise without strobes is ignored, line stays mark
      seen_low = 1'b0;
      d0 = dec_cnt;
      repeat (300) begin
         @(negedge clk);
         sd_bit = $urandom_range(0, 1);
      end
      repeat (400) @(negedge clk);
      check(seen_low == 1'b0, "R3 no strobe no output", seen_low, 0);
      check(dec_cnt == d0, "R1 idle line stays mark", dec_cnt - d0, 0);

      // R3: first bit after sync is 0 with no mark before it
      sync_ok = 1'b0;
      repeat (4) @(negedge clk);
      sync_ok = 1'b1;
      d0 = dec_cnt;
      put_bit(1'b0, 40);
      put_bit(1'b0, 40);
      put_bit(1'b0, 40);
      for (int k = 0; k < 9; k++) put_bit(1'b1, 40);
      send_char(9'h0A5, 1'b1, 40, 1'b1);
      drain();
      check(dec_cnt - d0 == 1, "R3 start needs prior mark", dec_cnt - d0, 1);

      // R7: zero stop bit discards the character
      d0 = dec_cnt;
      send_char(9'h033, 1'b0, 40, 1'b0);
      for (int k = 0; k < 3; k++) put_bit(1'b1, 40);
      send_char(9'h0C6, 1'b1, 40, 1'b1);
      drain();
      check(dec_cnt - d0 == 1, "R7 framing error dropped", dec_cnt - d0, 1);

      // R5: slow input never shortens
      seen_short = 1'b0;
      s0 = short_cnt;
      for (int k = 0; k < 8; k++) send_char(9'($urandom), 1'b1, 40, 1'b1);
      drain();
      check(short_cnt == s0, "R5 no shortening when slow", short_cnt - s0, 0);
      check(seen_short == 1'b0, "R5 stop_short stays low", seen_short, 0);

      // R5: burst then slightly fast stream must shorten, no loss
      seen_short = 1'b0;
      seen_hi = 1'b0;
      seen_ovr = 1'b0;
      s0 = short_cnt;
      bad_stop = 0;
      for (int k = 0; k < 7; k++) send_char(9'($urandom), 1'b1, 4, 1'b1);
      for (int k = 0; k < 30; k++) begin
         p = (k % 2 == 0) ? 31 : 32;
         send_char(9'($urandom), 1'b1, p, 1'b1);
      end
      drain();
      check(short_cnt > s0, "R5 shortened stops seen", short_cnt - s0, 1);
      check(seen_short == 1'b1, "R5 stop_short flagged", seen_short, 1);
      check(seen_hi == 1'b1, "R5 buf_hi raised", seen_hi, 1);
      check(bad_stop == 0, "R5 stop not below short length", bad_stop, 0);
      check(seen_ovr == 1'b0, "R8 no drop while shortening", seen_ovr, 0);

      // R8: overrun drops and pulses ovr
      cmp_en = 1'b0;
      seen_ovr = 1'b0;
      for (int k = 0; k < 14; k++) send_char(9'($urandom), 1'b1, 3, 1'b0);
      check(seen_ovr == 1'b1, "R8 ovr pulse", seen_ovr, 1);
      check(buf_hi == 1'b1, "R5 buf_hi when full", buf_hi, 1);

      // R6: sync loss forces mark, flushes, ignores input
      @(negedge clk);
      sync_ok = 1'b0;
      @(negedge clk);
      check(txd == 1'b1, "R6 mark after sync loss", txd, 1);
      check(buf_hi == 1'b0, "R6 buffer flushed", buf_hi, 0);
      put_bit(1'b1, 4);
      send_char(9'h155, 1'b1, 8, 1'b0);
      repeat (1200) @(negedge clk);
      seen_low = 1'b0;
      sync_ok = 1'b1;
      repeat (800) @(negedge clk);
      check(seen_low == 1'b0, "R6 nothing leaks after sync loss", seen_low, 0);
      cmp_en = 1'b1;

      // recovery after resync
      d0 = dec_cnt;
      put_bit(1'b1, 40);
      for (int k = 0; k < 3; k++) send_char(9'($urandom), 1'b1, 40, 1'b1);
      drain();
      check(dec_cnt - d0 == 3, "R6 resumes after resync", dec_cnt - d0, 3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule